// File: doc/BRIEF.md
# Host-Side Mailbox and FIFO Register Window

This block is the host-facing register window of a board interface. It fits in an eight-address I/O window and decodes each register directly, with no pointer register. Two FIFOs carry bulk traffic between host and board, one in each direction. Each FIFO has a parameterized depth and exposes empty, half-full and full flags. Two 6-bit mailboxes carry single short messages, one in each direction. A maskable interrupt tells the host about FIFO and mailbox conditions.

The host uses a plain strobe bus: `h_cs` with `h_we`, a 3-bit address and an 8-bit write byte. Reads are combinational during the strobe cycle, and any side effect of a read takes place at the next clock edge. The board uses one valid/ready stream per direction:

- Outbound stream: `ob_valid` is high whenever the outbound FIFO holds data. `ob_data` stays stable until `ob_ready` takes the word.
- Inbound stream: `ib_ready` drops when the inbound FIFO is full. A word moves only in a cycle where `ib_valid` and `ib_ready` are both high.

The mailboxes and the global interrupt enable use single-cycle board strobes.

`word_mode` selects the data width. With it set, FIFO words are 16 bits wide and the high byte of a host write comes from address 1. With it clear, transfers are 8 bits wide and each FIFO offers half its depth. `word_mode` should change only while both FIFOs are empty.

Top module: `mbx_host_if`

## Requirements
- R1: Reading address 2 returns the status byte on `h_rdata[7:0]` (upper bits zero). The bits are:
  - bit7: outbound mailbox not yet taken by the board
  - bit6: outbound FIFO full
  - bit5: inbound FIFO empty
  - bit4: outbound FIFO at or above half capacity
  - bit3: inbound FIFO at or above half capacity
  - bit2: inbound mailbox full
  - bit1: inbound FIFO full
  - bit0: outbound FIFO empty

  After reset the status byte is 0x21.
- R2: A host write to address 0 pushes one entry into the outbound FIFO unless it is full, in which case the write is dropped. The board receives entries in order on `ob_data`. `ob_valid` is high exactly when the FIFO holds data, and a word leaves only when `ob_valid` and `ob_ready` are both high.
- R3: The board pushes inbound entries when `ib_valid` and `ib_ready` are both high, and `ib_ready` is low while the inbound FIFO is full. A host read of address 0 returns the oldest entry and removes it. A read of address 0 while the FIFO is empty returns 0.
- R4: Each FIFO holds DEPTH entries in word mode and DEPTH/2 entries in byte mode. The half-full flag is set when the count is at least half of that capacity.
- R5: In word mode, a write to address 1 sets the high byte used by later writes to address 0. Inbound reads return all 16 bits. In byte mode, entries carry only the low byte and the upper byte reads as zero.
- R6: Mailboxes keep only bits [7:2] of a host write. A read of address 3 always returns 0 in bits [1:0].
- R7: A host write to address 3 loads the outbound mailbox and sets status bit7. A `bd_mb_rd` strobe clears bit7 but keeps the stored value.
- R8: Mask bit7 selects what a read of address 3 returns: the inbound mailbox when clear (the reset value), the outbound mailbox when set.
- R9: A `bd_mb_wr` strobe loads the inbound mailbox and sets status bit2. A host read of address 3 with mask bit7 clear clears status bit2. A read with mask bit7 set leaves bit2 unchanged. If a board write and a clearing read land in the same cycle, the board write wins.
- R10: A write to address 2 loads the mask. The mask bits enable these conditions:

  | Mask bit | Enables status bit | Condition |
  |---|---|---|
  | 6 | 2 | inbound mailbox full |
  | 5 | 1 | inbound FIFO full |
  | 3 | 5 | inbound FIFO empty |
  | 2 | 6 | outbound FIFO full |
  | 0 | 0 | outbound FIFO empty |

  Mask bits 4 and 1 are reserved and enable nothing. `h_irq` is the OR of all enabled conditions, ANDed with the global enable.
- R11: The global interrupt enable is clear after reset. It is set only by a `bd_irq_en` strobe. While it is clear, `h_irq` stays low whatever the mask holds.
- R12: A host write of any value to address 7 does the following:
  - In the same edge, it empties both FIFOs, clears both mailbox flags, the mask, the high byte and the global enable.
  - It raises `bd_reset` for exactly one cycle.

  A read of address 7 returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit transfers, 0: 8-bit transfers |
| h_cs | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 3 | Register address in the window |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 16 | Host read data during a read strobe |
| h_irq | output | 1 | Host interrupt request |
| ob_valid | output | 1 | Outbound FIFO has a word for the board |
| ob_ready | input | 1 | Board takes the outbound word |
| ob_data | output | 16 | Oldest outbound word |
| ib_valid | input | 1 | Board offers an inbound word |
| ib_ready | output | 1 | Inbound FIFO can accept a word |
| ib_data | input | 16 | Inbound word from the board |
| bd_mb_wr | input | 1 | Board writes the inbound mailbox |
| bd_mb_wdata | input | 6 | Inbound mailbox value |
| bd_imb_full | output | 1 | Inbound mailbox not yet read by the host |
| bd_mb_rd | input | 1 | Board takes the outbound mailbox |
| bd_omb_data | output | 6 | Outbound mailbox value |
| bd_omb_full | output | 1 | Outbound mailbox holds an untaken message |
| bd_irq_en | input | 1 | Board strobe that enables host interrupts |
| bd_reset | output | 1 | One-cycle reset pulse toward the board |

## Verification
The bench builds the block with DEPTH=8. At that depth, every fill level of both FIFOs can be stepped through one entry at a time, including one push past full. This covers the 4-entry byte-mode and 8-entry word-mode capacities and both half-full thresholds. Each of the eight mask bits is swept against two opposite status patterns, so every mapping and both reserved bits are compared with an interrupt value computed from the requirement. The mailbox tests cover both readback settings and both clearing paths. The reset write is checked against a fully loaded state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // window addresses
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_HIGH = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_MBOX = 3'd3;
  localparam logic [2:0] A_RST  = 3'd7;

  // status bit positions
  localparam int ST_OMB    = 7;
  localparam int ST_OFULL  = 6;
  localparam int ST_IEMPTY = 5;
  localparam int ST_OHALF  = 4;
  localparam int ST_IHALF  = 3;
  localparam int ST_IMB    = 2;
  localparam int ST_IFULL  = 1;
  localparam int ST_OEMPTY = 0;

  // mask bit positions (not aligned with status)
  localparam int MK_RSEL   = 7;
  localparam int MK_IMB    = 6;
  localparam int MK_IFULL  = 5;
  localparam int MK_IEMPTY = 3;
  localparam int MK_OFULL  = 2;
  localparam int MK_OEMPTY = 0;
  localparam logic [7:0] MK_WRITABLE = 8'hED;

  localparam int MB_W = 6;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } fifo_flags_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         narrow,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output fifo_flags_t  flags
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LIM_WIDE   = (AW+1)'(DEPTH);
  localparam logic [AW:0] LIM_NARROW = (AW+1)'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic [AW:0]   lim;
  logic          do_push, do_pop;

  assign lim         = narrow ? LIM_NARROW : LIM_WIDE;
  assign flags.full  = (cnt >= lim);
  assign flags.half  = (cnt >= (lim >> 1));
  assign flags.empty = (cnt == '0);
  assign do_push     = push && !flags.full;
  assign do_pop      = pop && !flags.empty;
  assign head        = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= push_data;
  end
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            mask_we,
  input  logic [7:0]      mask_wdata,
  input  logic            omb_we,
  input  logic [MB_W-1:0] omb_wdata,
  input  logic            imb_host_rd,
  input  logic            bd_mb_wr,
  input  logic [MB_W-1:0] bd_mb_wdata,
  input  logic            bd_mb_rd,
  input  logic            bd_irq_en,
  input  logic [7:0]      stat,
  output logic [7:0]      mask_q,
  output logic [MB_W-1:0] omb_val,
  output logic [MB_W-1:0] imb_val,
  output logic            omb_full,
  output logic            imb_full,
  output logic            irq
);
  timeunit 1ns;
  timeprecision 100ps;

  logic       glb_en;
  logic [7:0] cond;

  // place each status condition at the mask bit that enables it
  always_comb begin
    cond            = '0;
    cond[MK_IMB]    = stat[ST_IMB];
    cond[MK_IFULL]  = stat[ST_IFULL];
    cond[MK_IEMPTY] = stat[ST_IEMPTY];
    cond[MK_OFULL]  = stat[ST_OFULL];
    cond[MK_OEMPTY] = stat[ST_OEMPTY];
  end

  assign irq = glb_en && |(mask_q & cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      omb_val  <= '0;
      imb_val  <= '0;
      omb_full <= 1'b0;
      imb_full <= 1'b0;
      glb_en   <= 1'b0;
    end else if (clr) begin
      mask_q   <= '0;
      omb_val  <= '0;
      imb_val  <= '0;
      omb_full <= 1'b0;
      imb_full <= 1'b0;
      glb_en   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata & MK_WRITABLE;
      if (bd_irq_en) glb_en <= 1'b1;
      if (omb_we) begin
        omb_val  <= omb_wdata;
        omb_full <= 1'b1;
      end else if (bd_mb_rd) begin
        omb_full <= 1'b0;
      end
      if (bd_mb_wr) begin
        imb_val  <= bd_mb_wdata;
        imb_full <= 1'b1;
      end else if (imb_host_rd) begin
        imb_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic        h_cs,
  input  logic        h_we,
  input  logic [2:0]  h_addr,
  input  logic [7:0]  h_wdata,
  output logic [15:0] h_rdata,
  output logic        h_irq,
  output logic        ob_valid,
  input  logic        ob_ready,
  output logic [15:0] ob_data,
  input  logic        ib_valid,
  output logic        ib_ready,
  input  logic [15:0] ib_data,
  input  logic        bd_mb_wr,
  input  logic [5:0]  bd_mb_wdata,
  output logic        bd_imb_full,
  input  logic        bd_mb_rd,
  output logic [5:0]  bd_omb_data,
  output logic        bd_omb_full,
  input  logic        bd_irq_en,
  output logic        bd_reset
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 16;

  logic          wr, rd, clr_now;
  logic [7:0]    hi_q;
  logic [DW-1:0] ob_push_data, ib_push_data, ib_head;
  fifo_flags_t   ob_f, ib_f;
  logic [7:0]    stat_w, mask_q;
  logic [MB_W-1:0] omb_val, imb_val;
  logic          omb_full, imb_full;
  logic          rsel_w;
  logic [MB_W-1:0] mb_rd_val;

  assign wr      = h_cs && h_we;
  assign rd      = h_cs && !h_we;
  assign clr_now = wr && (h_addr == A_RST);
  assign rsel_w  = mask_q[MK_RSEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      bd_reset <= 1'b0;
    end else begin
      bd_reset <= clr_now;
      if (clr_now) hi_q <= '0;
      else if (wr && h_addr == A_HIGH) hi_q <= h_wdata;
    end
  end

  assign ob_push_data = word_mode ? {hi_q, h_wdata} : {8'h00, h_wdata};
  assign ib_push_data = word_mode ? ib_data : {8'h00, ib_data[7:0]};

  mbx_fifo #(.W(DW), .DEPTH(DEPTH)) u_ob (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .narrow(!word_mode),
    .push(wr && h_addr == A_DATA), .push_data(ob_push_data),
    .pop(ob_valid && ob_ready), .head(ob_data), .flags(ob_f)
  );

  mbx_fifo #(.W(DW), .DEPTH(DEPTH)) u_ib (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .narrow(!word_mode),
    .push(ib_valid && ib_ready), .push_data(ib_push_data),
    .pop(rd && h_addr == A_DATA), .head(ib_head), .flags(ib_f)
  );

  assign ob_valid = !ob_f.empty;
  assign ib_ready = !ib_f.full;

  always_comb begin
    stat_w            = '0;
    stat_w[ST_OMB]    = omb_full;
    stat_w[ST_OFULL]  = ob_f.full;
    stat_w[ST_IEMPTY] = ib_f.empty;
    stat_w[ST_OHALF]  = ob_f.half;
    stat_w[ST_IHALF]  = ib_f.half;
    stat_w[ST_IMB]    = imb_full;
    stat_w[ST_IFULL]  = ib_f.full;
    stat_w[ST_OEMPTY] = ob_f.empty;
  end

  mbx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr_now),
    .mask_we(wr && h_addr == A_STAT), .mask_wdata(h_wdata),
    .omb_we(wr && h_addr == A_MBOX), .omb_wdata(h_wdata[7:2]),
    .imb_host_rd(rd && h_addr == A_MBOX && !rsel_w),
    .bd_mb_wr(bd_mb_wr), .bd_mb_wdata(bd_mb_wdata),
    .bd_mb_rd(bd_mb_rd), .bd_irq_en(bd_irq_en), .stat(stat_w),
    .mask_q(mask_q), .omb_val(omb_val), .imb_val(imb_val),
    .omb_full(omb_full), .imb_full(imb_full), .irq(h_irq)
  );

  assign mb_rd_val = rsel_w ? omb_val : imb_val;

  always_comb begin
    h_rdata = '0;
    if (rd) begin
      case (h_addr)
        A_DATA:  h_rdata = ib_f.empty ? '0 : ib_head;
        A_STAT:  h_rdata = {8'h00, stat_w};
        A_MBOX:  h_rdata = {8'h00, mb_rd_val, 2'b00};
        default: h_rdata = '0;
      endcase
    end
  end

  assign bd_omb_data = omb_val;
  assign bd_omb_full = omb_full;
  assign bd_imb_full = imb_full;
endmodule

// File: rtl/mbx_host_if_chk.sv
module mbx_host_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_cs,
  input logic        h_we,
  input logic [2:0]  h_addr,
  input logic [1:0]  rdata_lo,
  input logic        h_irq,
  input logic        ob_valid,
  input logic        ob_ready,
  input logic [15:0] ob_data,
  input logic        bd_mb_wr,
  input logic        bd_reset,
  input logic [7:0]  stat,
  input logic        rsel
);
  timeunit 1ns;
  timeprecision 100ps;

  logic hw_rst, hw_mb, hr_mb;
  assign hw_rst = h_cs && h_we && (h_addr == 3'd7);
  assign hw_mb  = h_cs && h_we && (h_addr == 3'd3);
  assign hr_mb  = h_cs && !h_we && (h_addr == 3'd3);

  p_empty_full_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[5] && stat[1]) && !(stat[6] && stat[0]));

  p_ob_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready && !hw_rst |=> ob_valid && $stable(ob_data));

  p_mb_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hr_mb |-> rdata_lo == 2'b00);

  p_omb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mb |=> stat[7]);

  p_imb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hr_mb && !rsel && !bd_mb_wr |=> !stat[2]);

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bd_reset |-> !h_irq);

  p_reset_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> bd_reset);
endmodule

bind mbx_host_if mbx_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_we(h_we), .h_addr(h_addr),
  .rdata_lo(h_rdata[1:0]), .h_irq(h_irq), .ob_valid(ob_valid),
  .ob_ready(ob_ready), .ob_data(ob_data), .bd_mb_wr(bd_mb_wr),
  .bd_reset(bd_reset), .stat(stat_w), .rsel(rsel_w)
);

// File: tb/sim_mbx_host_if.sv
module sim_mbx_host_if;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 8;

  logic        clk = 1'b0, rst_n = 1'b0, word_mode = 1'b0;
  logic        h_cs = 1'b0, h_we = 1'b0;
  logic [2:0]  h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_irq, ob_valid, ib_ready, bd_imb_full, bd_omb_full, bd_reset;
  logic        ob_ready = 1'b0, ib_valid = 1'b0;
  logic        bd_mb_wr = 1'b0, bd_mb_rd = 1'b0, bd_irq_en = 1'b0;
  logic [15:0] ob_data, ib_data = '0;
  logic [5:0]  bd_mb_wdata = '0, bd_omb_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mbx_host_if #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .h_cs(h_cs), .h_we(h_we),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_data(ib_data),
    .bd_mb_wr(bd_mb_wr), .bd_mb_wdata(bd_mb_wdata), .bd_imb_full(bd_imb_full),
    .bd_mb_rd(bd_mb_rd), .bd_omb_data(bd_omb_data), .bd_omb_full(bd_omb_full),
    .bd_irq_en(bd_irq_en), .bd_reset(bd_reset)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_cs = 1'b0; h_we = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_we = 1'b0; h_addr = a;
    #1 d = h_rdata;
    @(negedge clk);
    h_cs = 1'b0;
  endtask

  task automatic ob_take(input string tag, input logic [15:0] exp);
    @(negedge clk);
    #1;
    chk({tag, " ob_valid"}, {15'd0, ob_valid}, 16'd1);
    chk({tag, " ob_data"}, ob_data, exp);
    ob_ready = 1'b1;
    @(negedge clk);
    ob_ready = 1'b0;
  endtask

  task automatic ib_give(input string tag, input logic [15:0] d, input bit exp_rdy);
    @(negedge clk);
    #1;
    chk({tag, " ib_ready"}, {15'd0, ib_ready}, {15'd0, exp_rdy});
    ib_valid = 1'b1; ib_data = d;
    @(negedge clk);
    ib_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_stat(int oc, int ic, int cap, bit omb, bit imb);
    logic [7:0] s;
    s[7] = omb;
    s[6] = (oc == cap);
    s[5] = (ic == 0);
    s[4] = (oc >= cap / 2);
    s[3] = (ic >= cap / 2);
    s[2] = imb;
    s[1] = (ic == cap);
    s[0] = (oc == 0);
    return s;
  endfunction

  function automatic logic exp_irq(logic [7:0] m, logic [7:0] s, bit en);
    return en && ((m[6] && s[2]) || (m[5] && s[1]) || (m[3] && s[5]) ||
                  (m[2] && s[6]) || (m[0] && s[0]));
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    hrd(3'd2, d);
    chk("R1 reset status", d, 16'h0021);
    chk("R11 reset irq", {15'd0, h_irq}, 16'd0);
    chk("R2 reset ob_valid", {15'd0, ob_valid}, 16'd0);
    chk("R3 reset ib_ready", {15'd0, ib_ready}, 16'd1);

    // R2/R4 byte-mode outbound fill, one past full
    cap = DEPTH / 2;
    for (int k = 1; k <= cap + 1; k++) begin
      hwr(3'd0, 8'h10 + 8'(k));
      hrd(3'd2, d);
      chk("R4 byte ob fill status", d, {8'h00, exp_stat((k > cap) ? cap : k, 0, cap, 0, 0)});
    end
    for (int k = 1; k <= cap; k++) ob_take("R2 byte ob drain", 16'h0010 + 16'(k));
    #1 chk("R2 ob empty after drain", {15'd0, ob_valid}, 16'd0);

    // R5/R4 word-mode outbound
    word_mode = 1'b1;
    cap = DEPTH;
    for (int k = 1; k <= cap + 1; k++) begin
      hwr(3'd1, 8'hA0 + 8'(k));
      hwr(3'd0, 8'(k));
      hrd(3'd2, d);
      chk("R4 word ob fill status", d, {8'h00, exp_stat((k > cap) ? cap : k, 0, cap, 0, 0)});
    end
    for (int k = 1; k <= cap; k++) ob_take("R5 word ob data", {8'hA0 + 8'(k), 8'(k)});

    // R3 word-mode inbound
    for (int k = 1; k <= cap + 1; k++) ib_give("R3 word ib", 16'hB000 + 16'(k), k <= cap);
    hrd(3'd2, d);
    chk("R3 ib full status", d, {8'h00, exp_stat(0, cap, cap, 0, 0)});
    for (int k = 1; k <= cap; k++) begin
      hrd(3'd0, d);
      chk("R5 word ib read", d, 16'hB000 + 16'(k));
    end
    hrd(3'd0, d);
    chk("R3 empty read", d, 16'h0000);
    hrd(3'd2, d);
    chk("R3 drained status", d, 16'h0021);

    // R4/R5 byte-mode inbound
    word_mode = 1'b0;
    cap = DEPTH / 2;
    for (int k = 1; k <= cap; k++) begin
      ib_give("R4 byte ib", 16'h1230 + 16'(k), 1'b1);
      hrd(3'd2, d);
      chk("R4 byte ib status", d, {8'h00, exp_stat(0, k, cap, 0, 0)});
    end
    for (int k = 1; k <= cap; k++) begin
      hrd(3'd0, d);
      chk("R5 byte ib read", d, 16'h0030 + 16'(k));
    end

    // R6/R7/R8 outbound mailbox
    hwr(3'd3, 8'hFF);
    hrd(3'd2, d);
    chk("R7 omb status set", d, 16'h00A1);
    #1 chk("R7 omb board data", {10'd0, bd_omb_data}, 16'h003F);
    chk("R7 omb board full", {15'd0, bd_omb_full}, 16'd1);
    hrd(3'd3, d);
    chk("R8 select clear reads inbound", d, 16'h0000);
    @(negedge clk) bd_mb_rd = 1'b1;
    @(negedge clk) bd_mb_rd = 1'b0;
    hrd(3'd2, d);
    chk("R7 board read clears flag", d, 16'h0021);
    hwr(3'd2, 8'h80);
    hrd(3'd3, d);
    chk("R7 R6 value kept after board read", d, 16'h00FC);

    // R9 inbound mailbox
    @(negedge clk) begin bd_mb_wr = 1'b1; bd_mb_wdata = 6'h2A; end
    @(negedge clk) bd_mb_wr = 1'b0;
    hrd(3'd2, d);
    chk("R9 imb status set", d, 16'h0025);
    #1 chk("R9 imb board flag", {15'd0, bd_imb_full}, 16'd1);
    hrd(3'd3, d);
    chk("R8 select set reads outbound", d, 16'h00FC);
    hrd(3'd2, d);
    chk("R9 select set keeps flag", d, 16'h0025);
    hwr(3'd2, 8'h00);
    hrd(3'd3, d);
    chk("R6 R9 imb read value", d, 16'h00A8);
    hrd(3'd2, d);
    chk("R9 host read clears flag", d, 16'h0021);

    // R11 global enable
    hwr(3'd2, 8'h01);
    #1 chk("R11 irq gated before enable", {15'd0, h_irq}, 16'd0);
    @(negedge clk) bd_irq_en = 1'b1;
    @(negedge clk) bd_irq_en = 1'b0;
    #1 chk("R11 irq after enable", {15'd0, h_irq}, 16'd1);

    // R10 mask sweep, idle state 0x21
    for (int b = 0; b < 8; b++) begin
      hwr(3'd2, 8'(1 << b));
      #1 chk($sformatf("R10 idle mask bit %0d", b), {15'd0, h_irq},
             {15'd0, exp_irq(8'(1 << b), 8'h21, 1'b1)});
    end
    // loaded state: ob full, ib full, imb full (byte mode)
    hwr(3'd2, 8'h00);
    for (int k = 0; k < DEPTH / 2; k++) hwr(3'd0, 8'(k));
    for (int k = 0; k < DEPTH / 2; k++) ib_give("R10 load ib", 16'(k), 1'b1);
    @(negedge clk) begin bd_mb_wr = 1'b1; bd_mb_wdata = 6'h01; end
    @(negedge clk) bd_mb_wr = 1'b0;
    hrd(3'd2, d);
    chk("R1 loaded status", d, {8'h00, exp_stat(DEPTH / 2, DEPTH / 2, DEPTH / 2, 0, 1)});
    for (int b = 0; b < 8; b++) begin
      hwr(3'd2, 8'(1 << b));
      #1 chk($sformatf("R10 loaded mask bit %0d", b), {15'd0, h_irq},
             {15'd0, exp_irq(8'(1 << b), d[7:0], 1'b1)});
    end

    // R12 reset write
    hwr(3'd3, 8'h40);
    hwr(3'd7, 8'h5A);
    #1 chk("R12 bd_reset pulse", {15'd0, bd_reset}, 16'd1);
    chk("R12 R11 irq off in reset", {15'd0, h_irq}, 16'd0);
    @(negedge clk);
    #1 chk("R12 bd_reset one cycle", {15'd0, bd_reset}, 16'd0);
    chk("R12 omb cleared", {15'd0, bd_omb_full}, 16'd0);
    chk("R12 imb cleared", {15'd0, bd_imb_full}, 16'd0);
    hrd(3'd2, d);
    chk("R12 status after reset", d, 16'h0021);
    hrd(3'd0, d);
    chk("R12 inbound emptied", d, 16'h0000);
    hwr(3'd2, 8'h01);
    #1 chk("R11 enable cleared by reset", {15'd0, h_irq}, 16'd0);
    hrd(3'd7, d);
    chk("R12 read of reset address", d, 16'h0000);
    #1 chk("R12 read gives no pulse", {15'd0, bd_reset}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule